// File: doc/BRIEF.md
# Multi-Match Ternary Header Matcher

This block holds a small table of ternary entries and compares a 72-bit header key against all of them in the same clock cycle. The key joins the source address in bits 71:40, the destination address in bits 39:8 and the protocol number in bits 7:0. Each entry carries a value, a care mask of equal width and a live flag. Address fields are matched as prefixes by clearing the low mask bits. The protocol field is matched exactly by setting all eight of its mask bits, or treated as a wildcard by clearing them. The result is not reduced to a single winner. The block returns one hit bit per entry, so any number of entries can match a key at once.

Rules with the same address and protocol specification share one entry. A per-rule pointer register names the entry that each rule uses. An expansion stage copies each entry's hit bit to every rule that points at it, and this produces a per-rule hit vector next to the entry vector.

Entries are rewritten at run time through a write port that moves 18 bits per cycle. A small controller has two states. IDLE accepts a write request and goes to FILL. FILL stays in FILL while beats remain, and after the last beat it returns to IDLE. The controller drives `wr_ready` low while a write is in progress, and for that time it forces the hit bit of the entry being written to 0.

Top module: `tern_rule_matcher`

## Requirements
- R1: After reset, `wr_ready` is 1, `hit_vld` is 0, both hit vectors are 0, every entry is not live, and rule r points at entry r mod N_ENT.
- R2: Entry e matches key k when it is live and `((k ^ value) & care) == 0`. A care bit of 1 compares that key bit, and a care bit of 0 ignores it.
- R3: A key presented with `key_vld` at a rising edge yields `hit_vld`=1 with both vectors after that same edge. A cycle without `key_vld` yields `hit_vld`=0 and all-zero vectors.
- R4: `ent_hit` is unencoded. Bit e is 1 for every matching entry, and several bits can be set together.
- R5: An entry whose live flag is 0 never matches, whatever its value and mask.
- R6: A `wr_req` taken while `wr_ready` is 1 holds `wr_ready` low for exactly 4 cycles. Beat b writes value and mask bits [18b+17:18b], for b = 0 to 3 in ascending order, and the last beat loads the live flag. The first lookup after `wr_ready` returns uses the new contents.
- R7: While a write is in progress, the hit bit of the target entry is 0. All other entries match normally.
- R8: A `wr_req` asserted while `wr_ready` is 0 is ignored and leaves every entry unchanged.
- R9: Rule bit r of `rule_hit` equals the `ent_hit` bit of the entry that rule r points at. A `map_we` pulse sets the pointer of rule `map_rule` to `map_ent`, and the new pointer is used from the next lookup onward. Any number of rules may point at the same entry.
- R10: A rule whose pointer is N_ENT or larger reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_vld | input | 1 | Key present this cycle |
| key | input | KEY_W | Header key {src, dst, proto} |
| wr_req | input | 1 | Request to rewrite one entry |
| wr_idx | input | IDX_W | Entry index to rewrite |
| wr_value | input | KEY_W | New entry value |
| wr_care | input | KEY_W | New care mask (1 = compare this bit) |
| wr_live | input | 1 | New live flag |
| wr_ready | output | 1 | 1 when no write is in progress |
| map_we | input | 1 | Write one rule pointer |
| map_rule | input | RULE_W | Rule whose pointer is written |
| map_ent | input | IDX_W | Entry index for that rule |
| hit_vld | output | 1 | Result vectors are valid |
| ent_hit | output | N_ENT | One hit bit per entry |
| rule_hit | output | N_RULE | One hit bit per rule |

## Verification
Lookup results appear one edge after the key is sampled, so the driver pushes the expected entry and rule vectors at the falling edge where it presents the key. The monitor pops that item at the next falling edge, where `hit_vld` must be high. A write takes 4 cycles: the bench stamps the falling edge after the request and expects `wr_ready` back exactly 4 cycles later. Its model marks the target entry as dark during those cycles, so lookups issued mid-write expect that entry's hit bit to be 0. Pointer changes and table contents enter the model only at the falling edge after they take effect, so every expected value reflects the state seen at the sampling edge.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } wr_state_e;
endpackage

// File: rtl/tcm_wr_fsm.sv
module tcm_wr_fsm
    import tcm_pkg::*;
#(
    parameter int KEY_W   = 72,
    parameter int SLICE_W = 18,
    parameter int IDX_W   = 6,
    localparam int N_BEAT = KEY_W / SLICE_W,
    localparam int BEAT_W = $clog2(N_BEAT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic               wr_live,
    output logic               ready,
    output logic [IDX_W-1:0]   tgt_idx,
    output logic               slice_we,
    output logic [BEAT_W-1:0]  beat,
    output logic [SLICE_W-1:0] slice_val,
    output logic [SLICE_W-1:0] slice_care,
    output logic               commit,
    output logic               commit_live
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(N_BEAT - 1);

    wr_state_e          state_q, state_d;
    logic [BEAT_W-1:0]  beat_q;
    logic [IDX_W-1:0]   stg_idx;
    logic [KEY_W-1:0]   stg_val, stg_care;
    logic               stg_live;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_req) state_d = ST_FILL;
            ST_FILL: if (beat_q == LAST_BEAT) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with beat counter and staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            stg_idx  <= '0;
            stg_val  <= '0;
            stg_care <= '0;
            stg_live <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wr_req) begin
                beat_q   <= '0;
                stg_idx  <= wr_idx;
                stg_val  <= wr_value;
                stg_care <= wr_care;
                stg_live <= wr_live;
            end else if (state_q == ST_FILL) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ready       = 1'b1;
        slice_we    = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_FILL: begin
                ready    = 1'b0;
                slice_we = 1'b1;
                commit   = (beat_q == LAST_BEAT);
            end
            default: ready = 1'b1;
        endcase
        tgt_idx     = stg_idx;
        beat        = beat_q;
        slice_val   = stg_val[beat_q*SLICE_W +: SLICE_W];
        slice_care  = stg_care[beat_q*SLICE_W +: SLICE_W];
        commit_live = stg_live;
    end
endmodule

// File: rtl/tcm_entry_array.sv
module tcm_entry_array #(
    parameter int KEY_W   = 72,
    parameter int SLICE_W = 18,
    parameter int N_ENT   = 33,
    parameter int IDX_W   = 6,
    localparam int N_BEAT = KEY_W / SLICE_W,
    localparam int BEAT_W = $clog2(N_BEAT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   key,
    input  logic               busy,
    input  logic [IDX_W-1:0]   tgt_idx,
    input  logic               slice_we,
    input  logic [BEAT_W-1:0]  beat,
    input  logic [SLICE_W-1:0] slice_val,
    input  logic [SLICE_W-1:0] slice_care,
    input  logic               commit,
    input  logic               commit_live,
    output logic [N_ENT-1:0]   match
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [KEY_W-1:0] val_q, care_q;
        logic             live_q;
        logic             sel;

        assign sel = (tgt_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q  <= '0;
                care_q <= '0;
                live_q <= 1'b0;
            end else begin
                if (slice_we && sel) begin
                    val_q[beat*SLICE_W +: SLICE_W]  <= slice_val;
                    care_q[beat*SLICE_W +: SLICE_W] <= slice_care;
                end
                if (commit && sel) live_q <= commit_live;
            end
        end

        assign match[e] = live_q && (((key ^ val_q) & care_q) == '0)
                          && !(busy && sel);
    end
endmodule

// File: rtl/tcm_rule_expand.sv
module tcm_rule_expand #(
    parameter int N_ENT  = 33,
    parameter int N_RULE = 48,
    parameter int IDX_W  = 6,
    parameter int RULE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [RULE_W-1:0] map_rule,
    input  logic [IDX_W-1:0]  map_ent,
    input  logic [N_ENT-1:0]  ent_match,
    output logic [N_RULE-1:0] rule_vec
);
    for (genvar r = 0; r < N_RULE; r++) begin : g_rule
        logic [IDX_W-1:0] ptr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q <= IDX_W'(r % N_ENT);
            else if (map_we && map_rule == RULE_W'(r))
                ptr_q <= map_ent;
        end

        assign rule_vec[r] = (ptr_q < IDX_W'(N_ENT)) ? ent_match[ptr_q] : 1'b0;
    end
endmodule

// File: rtl/tern_rule_matcher.sv
module tern_rule_matcher
    import tcm_pkg::*;
#(
    parameter int KEY_W   = 72,
    parameter int SLICE_W = 18,
    parameter int N_ENT   = 33,
    parameter int N_RULE  = 48,
    localparam int IDX_W  = $clog2(N_ENT + 1),
    localparam int RULE_W = $clog2(N_RULE),
    localparam int N_BEAT = KEY_W / SLICE_W,
    localparam int BEAT_W = $clog2(N_BEAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_vld,
    input  logic [KEY_W-1:0]  key,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_care,
    input  logic              wr_live,
    output logic              wr_ready,
    input  logic              map_we,
    input  logic [RULE_W-1:0] map_rule,
    input  logic [IDX_W-1:0]  map_ent,
    output logic              hit_vld,
    output logic [N_ENT-1:0]  ent_hit,
    output logic [N_RULE-1:0] rule_hit
);
    logic [IDX_W-1:0]   tgt_idx;
    logic               slice_we, commit, commit_live;
    logic [BEAT_W-1:0]  beat;
    logic [SLICE_W-1:0] slice_val, slice_care;
    logic [N_ENT-1:0]   ent_match;
    logic [N_RULE-1:0]  rule_vec;

    tcm_wr_fsm #(.KEY_W(KEY_W), .SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_care(wr_care), .wr_live(wr_live),
        .ready(wr_ready), .tgt_idx(tgt_idx), .slice_we(slice_we), .beat(beat),
        .slice_val(slice_val), .slice_care(slice_care),
        .commit(commit), .commit_live(commit_live)
    );

    tcm_entry_array #(.KEY_W(KEY_W), .SLICE_W(SLICE_W), .N_ENT(N_ENT),
                      .IDX_W(IDX_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .key(key), .busy(!wr_ready),
        .tgt_idx(tgt_idx), .slice_we(slice_we), .beat(beat),
        .slice_val(slice_val), .slice_care(slice_care),
        .commit(commit), .commit_live(commit_live), .match(ent_match)
    );

    tcm_rule_expand #(.N_ENT(N_ENT), .N_RULE(N_RULE), .IDX_W(IDX_W),
                      .RULE_W(RULE_W)) u_exp (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_rule(map_rule),
        .map_ent(map_ent), .ent_match(ent_match), .rule_vec(rule_vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_vld  <= 1'b0;
            ent_hit  <= '0;
            rule_hit <= '0;
        end else begin
            hit_vld  <= key_vld;
            ent_hit  <= key_vld ? ent_match : '0;
            rule_hit <= key_vld ? rule_vec  : '0;
        end
    end
endmodule

// File: rtl/tcm_chk.sv
module tcm_chk #(
    parameter int N_ENT  = 33,
    parameter int N_RULE = 48,
    parameter int N_BEAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_vld,
    input logic              wr_req,
    input logic              wr_ready,
    input logic              hit_vld,
    input logic [N_ENT-1:0]  ent_hit,
    input logic [N_RULE-1:0] rule_hit
);
    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_run <= '0;
        else if (wr_ready) busy_run <= '0;
        else               busy_run <= busy_run + 1'b1;
    end

    // R3
    hit_follows_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld |=> hit_vld);

    // R3
    idle_vectors_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |-> (ent_hit == '0 && rule_hit == '0));

    // R9
    rule_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_hit == '0) |-> (rule_hit == '0));

    // R6
    write_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_req) |=> !wr_ready);

    // R6
    busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (busy_run < 8'(N_BEAT)));

    // R6
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ready) |-> (busy_run == 8'(N_BEAT)));
endmodule

bind tern_rule_matcher tcm_chk #(.N_ENT(N_ENT), .N_RULE(N_RULE), .N_BEAT(N_BEAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .wr_req(wr_req),
    .wr_ready(wr_ready), .hit_vld(hit_vld), .ent_hit(ent_hit),
    .rule_hit(rule_hit)
);

// File: tb/tb_tern_rule_matcher.sv
`timescale 1ns/1ps
module tb_tern_rule_matcher;
    localparam int NE = 33;
    localparam int NR = 48;
    localparam int IW = 6;
    localparam int RW = 6;
    localparam int KW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_vld = 1'b0;
    logic [KW-1:0] key = '0;
    logic          wr_req = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0, wr_care = '0;
    logic          wr_live = 1'b0;
    logic          wr_ready;
    logic          map_we = 1'b0;
    logic [RW-1:0] map_rule = '0;
    logic [IW-1:0] map_ent = '0;
    logic          hit_vld;
    logic [NE-1:0] ent_hit;
    logic [NR-1:0] rule_hit;

    always #4 clk = ~clk;

    tern_rule_matcher dut (
        .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key(key),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_value(wr_value),
        .wr_care(wr_care), .wr_live(wr_live), .wr_ready(wr_ready),
        .map_we(map_we), .map_rule(map_rule), .map_ent(map_ent),
        .hit_vld(hit_vld), .ent_hit(ent_hit), .rule_hit(rule_hit)
    );

    // reference model
    logic [KW-1:0] m_val [NE];
    logic [KW-1:0] m_care[NE];
    logic          m_live[NE];
    logic [IW-1:0] m_map [NR];
    logic          m_busy = 1'b0;
    int            m_busy_idx = 0;

    logic [NE-1:0] q_ent[$];
    logic [NR-1:0] q_rule[$];
    string         q_tag[$];

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NE-1:0] exp_ent(logic [KW-1:0] k);
        logic [NE-1:0] v = '0;
        for (int e = 0; e < NE; e++)
            v[e] = m_live[e] && (((k ^ m_val[e]) & m_care[e]) == '0)
                   && !(m_busy && m_busy_idx == e);
        return v;
    endfunction

    function automatic logic [NR-1:0] exp_rule(logic [NE-1:0] ev);
        logic [NR-1:0] v = '0;
        for (int r = 0; r < NR; r++)
            v[r] = (int'(m_map[r]) < NE) ? ev[m_map[r]] : 1'b0;
        return v;
    endfunction

    // driver: present one key at the current falling edge
    task automatic lookup(logic [KW-1:0] k, string tag);
        logic [NE-1:0] ev;
        ev = exp_ent(k);
        q_ent.push_back(ev);
        q_rule.push_back(exp_rule(ev));
        q_tag.push_back(tag);
        key = k;
        key_vld = 1'b1;
        @(negedge clk);
        key_vld = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && hit_vld) begin
            if (q_ent.size() == 0) begin
                check("R3 unexpected hit_vld", 128'(hit_vld), 128'(0));
            end else begin
                logic [NE-1:0] ee;
                logic [NR-1:0] er;
                string t;
                ee = q_ent.pop_front();
                er = q_rule.pop_front();
                t  = q_tag.pop_front();
                check({t, " ent_hit"}, 128'(ent_hit), 128'(ee));
                check({t, " rule_hit"}, 128'(rule_hit), 128'(er));
            end
        end
    end

    int t_start;
    logic [KW-1:0] p_val, p_care;
    logic          p_live;

    task automatic start_write(int idx, logic [KW-1:0] v, logic [KW-1:0] c, logic l);
        wr_req = 1'b1; wr_idx = IW'(idx); wr_value = v; wr_care = c; wr_live = l;
        @(negedge clk);
        wr_req = 1'b0;
        m_busy = 1'b1; m_busy_idx = idx;
        p_val = v; p_care = c; p_live = l;
        t_start = cyc;
        check("R6 busy after request", 128'(wr_ready), 128'(0));
    endtask

    task automatic finish_write();
        while (!wr_ready) @(negedge clk);
        check("R6 busy length", 128'(cyc - t_start), 128'(4));
        m_val[m_busy_idx] = p_val;
        m_care[m_busy_idx] = p_care;
        m_live[m_busy_idx] = p_live;
        m_busy = 1'b0;
    endtask

    task automatic write_entry(int idx, logic [KW-1:0] v, logic [KW-1:0] c, logic l);
        start_write(idx, v, c, l);
        finish_write();
    endtask

    task automatic set_map(int r, int e);
        map_we = 1'b1; map_rule = RW'(r); map_ent = IW'(e);
        @(negedge clk);
        map_we = 1'b0;
        m_map[r] = IW'(e);
    endtask

    localparam logic [KW-1:0] K1 = {32'h80FCA0F5, 32'hC0A83202, 8'h06};
    localparam logic [KW-1:0] K2 = {32'hC09E1234, 32'h01020304, 8'h11};
    localparam logic [KW-1:0] K3 = {32'h01010101, 32'h02020202, 8'h01};
    localparam logic [KW-1:0] K4 = {32'h80010203, 32'h0A0B0C0D, 8'h99};

    initial begin
        for (int e = 0; e < NE; e++) begin
            m_val[e] = '0; m_care[e] = '0; m_live[e] = 1'b0;
        end
        for (int r = 0; r < NR; r++) m_map[r] = IW'(r % NE);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 wr_ready", 128'(wr_ready), 128'(1));
        check("R1 hit_vld", 128'(hit_vld), 128'(0));
        check("R1 ent_hit", 128'(ent_hit), 128'(0));

        // R5: every entry has care 0 but is not live
        lookup(K1, "R5 empty table");
        lookup(K3, "R1 default map empty");

        // R6 table load
        write_entry(0,  {32'h0, 32'hC0A80000, 8'h06}, {32'h0, 32'hFFFF0000, 8'hFF}, 1'b1);
        write_entry(1,  {32'h0, 32'hC0A83202, 8'h06}, {32'h0, 32'hFFFFFFFF, 8'hFF}, 1'b1);
        write_entry(2,  {32'hC09E0000, 32'h0, 8'h11}, {32'hFFFF0000, 32'h0, 8'hFF}, 1'b1);
        write_entry(3,  {32'h0, 32'h0, 8'h06}, {32'h0, 32'h0, 8'hFF}, 1'b1);
        write_entry(4,  '0, '0, 1'b0);
        write_entry(32, K4, '1, 1'b1);

        // R2 R4 multi-hit patterns
        lookup(K1, "R4 multi hit");
        lookup(K2, "R2 source prefix udp");
        lookup(K3, "R5 invalid wildcard entry");
        lookup(K4, "R6 exact full key");
        lookup(K4 ^ (72'h1 << 71), "R6 slice3 bit");
        lookup(K4 ^ 72'h1, "R6 slice0 bit");
        lookup(K4 ^ (72'h1 << 35), "R6 slice1 bit");
        lookup(K4 ^ (72'h1 << 50), "R2 slice2 bit");

        // R3: no key, zero outputs
        @(negedge clk);
        check("R3 idle hit_vld", 128'(hit_vld), 128'(0));
        check("R3 idle ent_hit", 128'(ent_hit), 128'(0));

        // R9 R10 sharing and out of range
        set_map(5, 0);
        set_map(6, 0);
        set_map(40, 63);
        set_map(41, 33);
        lookup(K1, "R9 shared rules");
        lookup(K4, "R10 out of range pointer");

        // R7 R8: lookup mid-write and ignored request
        start_write(3, {32'h0, 32'h0, 8'h06}, {32'h0, 32'h0, 8'hFF}, 1'b1);
        lookup(K1, "R7 target dark during write");
        wr_req = 1'b1; wr_idx = IW'(1); wr_value = '0; wr_care = '1; wr_live = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        lookup(K1, "R7 still dark");
        finish_write();
        lookup(K1, "R8 entry1 unchanged");
        lookup(K1 ^ 72'h1, "R8 protocol mismatch");

        repeat (4) @(negedge clk);
        check("R3 queue drained", 128'(q_ent.size()), 128'(0));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule